// File: doc/BRIEF.md
# XOR-Parity Banked Dual-Mode Memory

This block is a single memory of `DEPTH` words that offers more access ports than its storage arrays have. The address space is interleaved over four data arrays: the two low address bits pick the array and the remaining bits give the row inside it. A fifth array holds, at every row, the bitwise XOR of the four data arrays at that row. Each array has two read ports and one write port. When several reads land on one array and its read ports are used up, the block rebuilds the wanted word from the other three data arrays and the parity array at the same row. It does not keep a full copy of the memory for the extra ports.

A mode input picks between two uses of the same hardware. In read-write mode, read ports 0 and 1 and the write port are live. In four-read mode, all four read ports are live and the write port is ignored. A request is sampled on one rising edge and its read data is on `rdata` during the following clock cycle. A write stores its word in its data array at once. In that same cycle it reads the other three data arrays at the same row. The parity array is rewritten one cycle later. Reads that need the parity row while that rewrite is still pending use the freshly computed parity word instead of the stored one.

Top module: `xmem_dual`

## Requirements
- R1: After reset every location reads as zero in both modes, and `rdata` is zero.
- R2: In read-write mode (`mode`=0), a word written at address A is returned by any read of A that is requested in a later cycle. Read data appears in the cycle after the request.
- R3: In read-write mode, two reads that fall on the same data array (same address bits [1:0]) both return correct data, including in a cycle with a write.
- R4: A read of the address being written in the same cycle returns the value held before that write.
- R5: A read requested in the cycle right after a write, which must be rebuilt at the row of that write, returns correct data. The parity update for that row is still pending at that point.
- R6: In four-read mode (`mode`=1), any combination of four read addresses returns correct data, including all four on one data array.
- R7: In four-read mode, `wr_en` has no effect: no location changes.
- R8: A read port whose valid bit is low returns zero. In read-write mode, ports 2 and 3 are unused and always return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all arrays |
| mode | input | 1 | 0: two reads and one write; 1: four reads |
| rd_vld | input | 4 | Per-port read request |
| rd_addr | input | 4*AW | Read addresses, port i at bits [i*AW +: AW] |
| wr_en | input | 1 | Write request (read-write mode only) |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rdata | output | 4*DW | Read data, port i at bits [i*DW +: DW], valid one cycle after the request |

## Verification
Every read result is due in the clock cycle after the edge that samples its request. A write is visible to reads requested from the next edge on. The parity rewrite lands one edge after the data write, so a read issued in the cycle in between exercises the forwarding path. The bench drives each request on a falling edge and lets one rising edge pass. It then compares all four `rdata` lanes on the next falling edge against a flat reference array. That array is updated only after the edge that commits the write, so a same-cycle read is expected to return the old word and a next-cycle read the new one.

// File: rtl/xmd_pkg.sv
package xmd_pkg;
    localparam int NBANK = 4;
    localparam int BW    = $clog2(NBANK);
    localparam int NARR  = NBANK + 1;
    localparam int NRD   = 4;
    localparam int NPORT = 2;

    typedef enum logic {
        MODE_RW = 1'b0,
        MODE_R4 = 1'b1
    } mode_e;
endpackage

// File: rtl/xmd_bank.sv
module xmd_bank #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int NRP   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NRP-1:0]           re,
    input  logic [NRP-1:0][AW-1:0]   ra,
    output logic [NRP-1:0][DW-1:0]   rq,
    input  logic                     we,
    input  logic [AW-1:0]            wa,
    input  logic [DW-1:0]            wd
);
    logic [DW-1:0] mem_q [DEPTH];

    // read-first array: a read in the write cycle returns the old word
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) mem_q[j] <= '0;
            rq <= '0;
        end else begin
            for (int p = 0; p < NRP; p++) begin
                if (re[p]) rq[p] <= mem_q[ra[p]];
            end
            if (we) mem_q[wa] <= wd;
        end
    end
endmodule

// File: rtl/xmd_alloc.sv
module xmd_alloc
    import xmd_pkg::*;
#(
    parameter int OW = 4
) (
    input  logic                              mode,
    input  logic [NRD-1:0]                    rd_act,
    input  logic [NRD-1:0][BW-1:0]            rd_bank,
    input  logic [NRD-1:0][OW-1:0]            rd_off,
    input  logic                              wr_act,
    input  logic [BW-1:0]                     wr_bank,
    input  logic [OW-1:0]                     wr_off,
    output logic [NARR-1:0][NPORT-1:0]        port_en,
    output logic [NARR-1:0][NPORT-1:0][OW-1:0] port_off,
    output logic [NRD-1:0]                    recon,
    output logic [NRD-1:0][NARR-1:0]          slot,
    output logic [NBANK-1:0]                  upd_slot,
    output logic                              overflow
);
    logic [1:0] used [NARR];
    logic [1:0] dcnt [NBANK];
    logic [1:0] dlim;

    always_comb begin
        port_en  = '0;
        port_off = '0;
        recon    = '0;
        slot     = '0;
        upd_slot = '0;
        overflow = 1'b0;
        for (int k = 0; k < NARR; k++)  used[k] = 2'd0;
        for (int k = 0; k < NBANK; k++) dcnt[k] = 2'd0;
        dlim = (mode == MODE_R4) ? 2'd2 : 2'd1;

        // parity-update reads claim a port on every other data array first
        if (wr_act) begin
            for (int k = 0; k < NBANK; k++) begin
                if (k != int'(wr_bank)) begin
                    port_en[k][used[k][0]]  = 1'b1;
                    port_off[k][used[k][0]] = wr_off;
                    upd_slot[k]             = used[k][0];
                    used[k]                 = used[k] + 2'd1;
                end
            end
        end

        // direct reads, up to dlim per array in port order
        for (int i = 0; i < NRD; i++) begin
            if (rd_act[i]) begin
                if (dcnt[rd_bank[i]] < dlim) begin
                    if (used[rd_bank[i]] == 2'd2) begin
                        overflow = 1'b1;
                    end else begin
                        port_en[rd_bank[i]][used[rd_bank[i]][0]]  = 1'b1;
                        port_off[rd_bank[i]][used[rd_bank[i]][0]] = rd_off[i];
                        slot[i][rd_bank[i]]                       = used[rd_bank[i]][0];
                        used[rd_bank[i]]                          = used[rd_bank[i]] + 2'd1;
                    end
                    dcnt[rd_bank[i]] = dcnt[rd_bank[i]] + 2'd1;
                end else begin
                    recon[i] = 1'b1;
                end
            end
        end

        // rebuilt reads take one port on every other array, parity included
        for (int i = 0; i < NRD; i++) begin
            if (recon[i]) begin
                for (int k = 0; k < NARR; k++) begin
                    if (k != int'(rd_bank[i])) begin
                        if (used[k] == 2'd2) begin
                            overflow = 1'b1;
                        end else begin
                            port_en[k][used[k][0]]  = 1'b1;
                            port_off[k][used[k][0]] = rd_off[i];
                            slot[i][k]              = used[k][0];
                            used[k]                 = used[k] + 2'd1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/xmem_dual.sv
module xmem_dual
    import xmd_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode,
    input  logic [NRD-1:0]    rd_vld,
    input  logic [NRD*AW-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [NRD*DW-1:0] rdata
);
    localparam int OW     = AW - BW;
    localparam int BDEPTH = DEPTH / NBANK;

    typedef struct packed {
        logic                       pend;
        logic [OW-1:0]              poff;
        logic [DW-1:0]              pdat;
        logic [BW-1:0]              pbank;
        logic [NBANK-1:0]           uslot;
        logic [NRD-1:0]             val;
        logic [NRD-1:0]             rec;
        logic [NRD-1:0][BW-1:0]     bank;
        logic [NRD-1:0][NARR-1:0]   slot;
        logic [NRD-1:0]             fwd;
        logic [NRD-1:0][DW-1:0]     fpar;
    } st_t;

    st_t s_d, s_q;

    logic [NRD-1:0]                    rd_act;
    logic [NRD-1:0][BW-1:0]            rd_bank;
    logic [NRD-1:0][OW-1:0]            rd_off;
    logic                              wr_act;
    logic [NARR-1:0][NPORT-1:0]        port_en;
    logic [NARR-1:0][NPORT-1:0][OW-1:0] port_off;
    logic [NRD-1:0]                    recon;
    logic [NRD-1:0][NARR-1:0]          slot;
    logic [NBANK-1:0]                  upd_slot;
    logic                              alloc_ovf;
    logic [NARR-1:0]                   bank_we;
    logic [NARR-1:0][OW-1:0]           bank_wa;
    logic [NARR-1:0][DW-1:0]           bank_wd;
    logic [NARR-1:0][NPORT-1:0][DW-1:0] brd;
    logic [DW-1:0]                     new_par;

    always_comb begin
        for (int i = 0; i < NRD; i++) begin
            rd_act[i]  = rd_vld[i] && ((mode == MODE_R4) || (i < 2));
            rd_bank[i] = rd_addr[i*AW +: BW];
            rd_off[i]  = rd_addr[i*AW+BW +: OW];
        end
        wr_act = wr_en && (mode == MODE_RW);
    end

    xmd_alloc #(.OW(OW)) u_alloc (
        .mode     (mode),
        .rd_act   (rd_act),
        .rd_bank  (rd_bank),
        .rd_off   (rd_off),
        .wr_act   (wr_act),
        .wr_bank  (wr_addr[BW-1:0]),
        .wr_off   (wr_addr[AW-1:BW]),
        .port_en  (port_en),
        .port_off (port_off),
        .recon    (recon),
        .slot     (slot),
        .upd_slot (upd_slot),
        .overflow (alloc_ovf)
    );

    for (genvar k = 0; k < NARR; k++) begin : g_arr
        xmd_bank #(.DW(DW), .DEPTH(BDEPTH), .NRP(NPORT)) u_bank (
            .clk (clk),
            .rst (rst),
            .re  (port_en[k]),
            .ra  (port_off[k]),
            .rq  (brd[k]),
            .we  (bank_we[k]),
            .wa  (bank_wa[k]),
            .wd  (bank_wd[k])
        );
    end

    always_comb begin
        // new parity word of the write accepted last cycle
        new_par = s_q.pdat;
        for (int k = 0; k < NBANK; k++) begin
            if (k != int'(s_q.pbank)) new_par = new_par ^ brd[k][s_q.uslot[k]];
        end

        for (int k = 0; k < NBANK; k++) begin
            bank_we[k] = wr_act && (wr_addr[BW-1:0] == BW'(k));
            bank_wa[k] = wr_addr[AW-1:BW];
            bank_wd[k] = wr_data;
        end
        bank_we[NBANK] = s_q.pend;
        bank_wa[NBANK] = s_q.poff;
        bank_wd[NBANK] = new_par;

        s_d       = s_q;
        s_d.pend  = wr_act;
        s_d.poff  = wr_addr[AW-1:BW];
        s_d.pdat  = wr_data;
        s_d.pbank = wr_addr[BW-1:0];
        s_d.uslot = upd_slot;
        s_d.val   = rd_act;
        s_d.rec   = recon;
        s_d.bank  = rd_bank;
        s_d.slot  = slot;
        for (int i = 0; i < NRD; i++) begin
            s_d.fwd[i]  = s_q.pend && recon[i] && (rd_off[i] == s_q.poff);
            s_d.fpar[i] = new_par;
        end
    end

    always_comb begin
        for (int i = 0; i < NRD; i++) begin
            logic [DW-1:0] word;
            word = '0;
            if (s_q.val[i]) begin
                if (!s_q.rec[i]) begin
                    word = brd[s_q.bank[i]][s_q.slot[i][s_q.bank[i]]];
                end else begin
                    for (int k = 0; k < NBANK; k++) begin
                        if (k != int'(s_q.bank[i])) word = word ^ brd[k][s_q.slot[i][k]];
                    end
                    word = word ^ (s_q.fwd[i] ? s_q.fpar[i] : brd[NBANK][s_q.slot[i][NBANK]]);
                end
            end
            rdata[i*DW +: DW] = word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R6
    port_budget_chk: assert property (@(posedge clk) disable iff (rst) !alloc_ovf);

    // R2
    par_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (mode == MODE_RW)) |=> bank_we[NBANK]);

    // R7
    no_write_4r_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_R4) |-> (bank_we[NBANK-1:0] == '0));

    for (genvar i = 0; i < NRD; i++) begin : g_chk
        // R8
        idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (!rd_vld[i] || ((mode == MODE_RW) && (i >= 2))) |=> (rdata[i*DW +: DW] == '0));
    end
endmodule

// File: tb/sim_xmem_dual.sv
module sim_xmem_dual;
    localparam int DW    = 16;
    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int OW    = 4;
    localparam int NRD   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode = 1'b0;
    logic [NRD-1:0]    rd_vld = '0;
    logic [NRD*AW-1:0] rd_addr = '0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic [NRD*DW-1:0] rdata;

    always #10 clk = ~clk;

    xmem_dual #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk (clk), .rst (rst), .mode (mode), .rd_vld (rd_vld), .rd_addr (rd_addr),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data), .rdata (rdata)
    );

    logic [DW-1:0] ref_mem [DEPTH];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(string tag, int port, logic [DW-1:0] act, logic [DW-1:0] want);
        n_vec++;
        if (act !== want) begin
            n_bad++;
            $display("FAIL %s port %0d: actual %h expected %h", tag, port, act, want);
        end
    endtask

    // one request cycle: drive, pass the edge, check all lanes
    task automatic step(string tag, logic m, logic [3:0] v,
                        logic [AW-1:0] a0, logic [AW-1:0] a1, logic [AW-1:0] a2, logic [AW-1:0] a3,
                        logic we, logic [AW-1:0] wa, logic [DW-1:0] wd);
        logic [AW-1:0] aa [4];
        logic [DW-1:0] want [4];
        aa = '{a0, a1, a2, a3};
        mode = m; rd_vld = v; rd_addr = {a3, a2, a1, a0};
        wr_en = we; wr_addr = wa; wr_data = wd;
        for (int i = 0; i < 4; i++)
            want[i] = (v[i] && (m || i < 2)) ? ref_mem[aa[i]] : '0;
        @(posedge clk);
        if (we && !m) ref_mem[wa] = wd;
        @(negedge clk);
        for (int i = 0; i < 4; i++) chk(tag, i, rdata[i*DW +: DW], want[i]);
    endtask

    task automatic t_reset;
        step("R1 reset four-read", 1'b1, 4'hF, 6'd0, 6'd1, 6'd2, 6'd63, 1'b0, 6'd0, '0);
        step("R1 reset same array", 1'b0, 4'h3, 6'd4, 6'd8, 6'd0, 6'd0, 1'b0, 6'd0, '0);
    endtask

    task automatic t_fill;
        for (int a = 0; a < DEPTH; a++) begin
            logic [AW-1:0] prv;
            prv = AW'((a + DEPTH - 1) % DEPTH);
            step("R2 fill", 1'b0, 4'h3, prv, AW'((a + 4) % DEPTH), 6'd0, 6'd0,
                 1'b1, AW'(a), DW'(32'hA000 ^ (a * 311)));
        end
        step("R2 readback", 1'b0, 4'h3, 6'd63, 6'd17, 6'd0, 6'd0, 1'b0, 6'd0, '0);
    endtask

    task automatic t_collide;
        // reads on array 2, write on array 2
        step("R3 same array with write", 1'b0, 4'h3, 6'd14, 6'd30, 6'd0, 6'd0, 1'b1, 6'd22, 16'h1234);
        // reads on array 2, write on array 0
        step("R3 same array other write", 1'b0, 4'h3, 6'd22, 6'd42, 6'd0, 6'd0, 1'b1, 6'd40, 16'h5A5A);
        step("R3 same array no write", 1'b0, 4'h3, 6'd40, 6'd44, 6'd0, 6'd0, 1'b0, 6'd0, '0);
    endtask

    task automatic t_rdold;
        step("R4 read during write", 1'b0, 4'h3, 6'd9, 6'd13, 6'd0, 6'd0, 1'b1, 6'd9, 16'hBEEF);
        step("R4 read after write", 1'b0, 4'h1, 6'd9, 6'd0, 6'd0, 6'd0, 1'b0, 6'd0, '0);
    endtask

    task automatic t_forward;
        // write row 1 of array 1; next cycle rebuild row 1 of array 0
        step("R5 write", 1'b0, 4'h0, 6'd0, 6'd0, 6'd0, 6'd0, 1'b1, 6'd5, 16'hC0DE);
        step("R5 rebuild pending row", 1'b0, 4'h3, 6'd0, 6'd4, 6'd0, 6'd0, 1'b1, 6'd21, 16'h7777);
        step("R5 four-read pending row", 1'b1, 4'hF, 6'd20, 6'd20, 6'd20, 6'd20, 1'b0, 6'd0, '0);
    endtask

    task automatic t_quad;
        step("R6 all one array", 1'b1, 4'hF, 6'd3, 6'd7, 6'd11, 6'd15, 1'b0, 6'd0, '0);
        step("R6 three plus one", 1'b1, 4'hF, 6'd1, 6'd5, 6'd9, 6'd2, 1'b0, 6'd0, '0);
        step("R6 two pairs", 1'b1, 4'hF, 6'd0, 6'd8, 6'd1, 6'd13, 1'b0, 6'd0, '0);
        step("R6 spread", 1'b1, 4'hF, 6'd60, 6'd61, 6'd62, 6'd63, 1'b0, 6'd0, '0);
    endtask

    task automatic t_ignore;
        step("R7 write in four-read", 1'b1, 4'hF, 6'd33, 6'd37, 6'd1, 6'd29, 1'b1, 6'd33, 16'hDEAD);
        step("R7 location unchanged", 1'b1, 4'h1, 6'd33, 6'd0, 6'd0, 6'd0, 1'b0, 6'd0, '0);
    endtask

    task automatic t_unused;
        step("R8 unused lanes", 1'b0, 4'hF, 6'd10, 6'd11, 6'd12, 6'd13, 1'b0, 6'd0, '0);
        step("R8 invalid lane", 1'b0, 4'h1, 6'd10, 6'd11, 6'd0, 6'd0, 1'b0, 6'd0, '0);
    endtask

    task automatic t_random;
        for (int n = 0; n < 300; n++) begin
            logic          m;
            logic [AW-1:0] ad [4];
            logic [AW-1:0] wa;
            m = 1'($urandom_range(0, 1));
            for (int i = 0; i < 4; i++)
                ad[i] = {OW'($urandom_range(0, 15)), 2'($urandom_range(0, 1))};
            wa = {OW'($urandom_range(0, 15)), 2'($urandom_range(0, 3))};
            step(m ? "R6 random four-read" : "R3 random read-write", m,
                 4'($urandom_range(0, 15)), ad[0], ad[1], ad[2], ad[3],
                 1'($urandom_range(0, 1)), wa, DW'($urandom));
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 4; i++) chk("R1 output after reset", i, rdata[i*DW +: DW], '0);
        rst = 1'b0;
        t_reset();
        t_fill();
        t_collide();
        t_rdold();
        t_forward();
        t_quad();
        t_ignore();
        t_unused();
        t_random();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule